// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the integer execute stage of a small RISC core. Each cycle it takes a 4-bit operation code, a first operand, an already-shifted second operand, the carry produced by the shifter and a request to update the condition flags. It returns a 32-bit result and a destination write-enable in the same cycle. It keeps the four condition flags (negative, zero, carry, overflow) in a register that is updated at the next clock edge.

There are sixteen operations. Six are bitwise: pass, invert, OR, XOR, AND and AND-with-complement. Six are add or subtract forms: plain add, add with carry, subtract, subtract with carry, and reverse subtract with and without carry. Four are compare and test forms that only affect the flags. The carry used by the carry-consuming forms is the registered carry flag. Operand shifting, register file access, condition evaluation and instruction decode belong to other blocks.

Top module: `alu_dp`

## Requirements
- R1: Operation codes are AND=0, EOR=1, SUB=2, RSB=3, ADD=4, ADC=5, SBC=6, RSC=7, TST=8, TEQ=9, CMP=10, CMN=11, ORR=12, MOV=13, BIC=14, MVN=15. The bitwise codes give: MOV=b, MVN=~b, ORR=a|b, EOR=a^b, AND=a&b, BIC=a&~b, where a is `opnd_a` and b is `opnd_b`.
- R2: The arithmetic codes give, modulo 2^32 with C the registered carry flag: ADD=a+b, ADC=a+b+C, SUB=a-b, SBC=a-b+C-1, RSB=b-a, RSC=b-a+C-1. CMP computes a-b and CMN computes a+b, and both drive that value on `result`.
- R3: `dest_we` is 0 for codes 8 to 11 and 1 for every other code.
- R4: When the flags update, N becomes bit 31 of the result and Z becomes 1 exactly when all 32 result bits are 0.
- R5: When a bitwise code (including TST and TEQ) updates the flags, C takes `shift_carry` and V keeps its value.
- R6: When an add form updates the flags, C is the carry out of bit 31. When a subtract form updates the flags, C is 1 exactly when no borrow occurs.
- R7: When an arithmetic code updates the flags, V is 1 exactly when the exact signed result lies outside the 32-bit signed range.
- R8: When `set_flags` is 0 and the code is not 8 to 11, all four flags keep their values.
- R9: Codes 8 to 11 update the flags whatever the value of `set_flags`.
- R10: During reset all four flags read 0.
- R11: `result` and `dest_we` follow the inputs without a clock edge. The flags change only at the rising edge after the operation is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_code | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, already shifted |
| shift_carry | input | 1 | Carry out of the shifter |
| set_flags | input | 1 | Flag update request |
| result | output | 32 | Operation result |
| dest_we | output | 1 | Destination write-enable |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The hardest cases to reach are the carry-consuming forms at operand extremes with a chosen carry value. The carry cannot be driven from a port: it only comes from an earlier operation. The bench therefore runs a flag-setting MOV first, with `shift_carry` set to the carry it wants, and then applies each code to every pair of 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF. Random operations follow, with random flag requests, to cover the hold and compare-always-update paths.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int unsigned DATA_W = 32;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } alu_flags_t;

    // Codes 8..11 only affect flags.
    function automatic logic op_is_compare(input logic [3:0] op);
        return op[3:2] == 2'b10;
    endfunction

    function automatic logic op_is_arith(input logic [3:0] op);
        return (op >= 4'd2 && op <= 4'd7) || op == 4'd10 || op == 4'd11;
    endfunction
endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (alu_op_e'(op))
            OP_AND, OP_TST: y = a & b;
            OP_EOR, OP_TEQ: y = a ^ b;
            OP_ORR:         y = a | b;
            OP_MOV:         y = b;
            OP_BIC:         y = a & ~b;
            OP_MVN:         y = ~b;
            default:        y = '0;
        endcase
    end
endmodule

// File: rtl/alu_adder_unit.sv
module alu_adder_unit
    import alu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         c_in,
    output logic [W-1:0] sum,
    output logic         c_out,
    output logic         ovf
);
    localparam int unsigned MSB = W - 1;

    logic [W-1:0] x, y;
    logic         cin;
    logic [W:0]   full;

    // One adder serves all six arithmetic codes and both compares.
    // Subtraction becomes x + ~y + 1; the carry out is then the inverted borrow.
    always_comb begin
        x   = a;
        y   = b;
        cin = 1'b0;
        unique case (alu_op_e'(op))
            OP_ADD, OP_CMN: begin x = a;  y = b;  cin = 1'b0; end
            OP_ADC:         begin x = a;  y = b;  cin = c_in; end
            OP_SUB, OP_CMP: begin x = a;  y = ~b; cin = 1'b1; end
            OP_SBC:         begin x = a;  y = ~b; cin = c_in; end
            OP_RSB:         begin x = ~a; y = b;  cin = 1'b1; end
            OP_RSC:         begin x = ~a; y = b;  cin = c_in; end
            default:        begin x = a;  y = b;  cin = 1'b0; end
        endcase
        full  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
        sum   = full[W-1:0];
        c_out = full[W];
        ovf   = (x[MSB] == y[MSB]) && (full[MSB] != x[MSB]);
    end
endmodule

// File: rtl/alu_dp.sv
module alu_dp
    import alu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   op_code,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         shift_carry,
    input  logic         set_flags,
    output logic [W-1:0] result,
    output logic         dest_we,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_c,
    output logic         flag_v
);
    localparam int unsigned MSB = W - 1;

    alu_flags_t   flags_d, flags_q;
    logic [W-1:0] logic_y, arith_y;
    logic         arith_c, arith_v;

    alu_logic_unit #(.W(W)) u_logic (
        .op (op_code),
        .a  (opnd_a),
        .b  (opnd_b),
        .y  (logic_y)
    );

    alu_adder_unit #(.W(W)) u_adder (
        .op    (op_code),
        .a     (opnd_a),
        .b     (opnd_b),
        .c_in  (flags_q.c),
        .sum   (arith_y),
        .c_out (arith_c),
        .ovf   (arith_v)
    );

    logic arith_d, cmp_d, upd_d;

    always_comb begin
        arith_d = op_is_arith(op_code);
        cmp_d   = op_is_compare(op_code);
        upd_d   = set_flags || cmp_d;
        result  = arith_d ? arith_y : logic_y;
        dest_we = !cmp_d;

        flags_d = flags_q;
        if (upd_d) begin
            flags_d.n = result[MSB];
            flags_d.z = (result == '0);
            flags_d.c = arith_d ? arith_c : shift_carry;
            flags_d.v = arith_d ? arith_v : flags_q.v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_c = flags_q.c;
    assign flag_v = flags_q.v;
endmodule

// File: rtl/alu_dp_chk.sv
module alu_dp_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [3:0]   op_code,
    input logic         shift_carry,
    input logic         set_flags,
    input logic [W-1:0] result,
    input logic         dest_we,
    input logic         flag_n,
    input logic         flag_z,
    input logic         flag_c,
    input logic         flag_v
);
    logic cmp_w, logic_w, upd_w;
    assign cmp_w   = (op_code >= 4'd8) && (op_code <= 4'd11);
    assign logic_w = (op_code <= 4'd1) || op_code == 4'd8 || op_code == 4'd9 || op_code >= 4'd12;
    assign upd_w   = set_flags || cmp_w;

    a_r3_compare_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_w |-> !dest_we);
    a_r3_other_writes: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_w |-> dest_we);
    a_r4_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
        upd_w |=> flag_n == $past(result[W-1]));
    a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        upd_w |=> flag_z == ($past(result) == '0));
    a_r5_shift_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_w && logic_w) |=> flag_c == $past(shift_carry));
    a_r5_v_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_w && logic_w) |=> $stable(flag_v));
    a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_w |=> $stable({flag_n, flag_z, flag_c, flag_v}));
    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |-> {flag_n, flag_z, flag_c, flag_v} == 4'b0000);
endmodule

bind alu_dp alu_dp_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_code     (op_code),
    .shift_carry (shift_carry),
    .set_flags   (set_flags),
    .result      (result),
    .dest_we     (dest_we),
    .flag_n      (flag_n),
    .flag_z      (flag_z),
    .flag_c      (flag_c),
    .flag_v      (flag_v)
);

// File: tb/alu_dp_tb.sv
module alu_dp_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic        shift_carry = 1'b0, set_flags = 1'b0;
    logic [31:0] result;
    logic        dest_we, flag_n, flag_z, flag_c, flag_v;

    int n_chk = 0, n_fail = 0;
    logic [3:0] mf = 4'b0000;   // bench model of {n,z,c,v}

    always #5 clk = ~clk;

    alu_dp u_dut (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference from the arithmetic definitions, using exact 64-bit integers.
    function automatic void model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                                  input logic [3:0] f, input logic sc, input logic s,
                                  output logic [31:0] r, output logic we, output logic [3:0] nf,
                                  output logic arith);
        longint ua, ub, sa, sb, u, sg, ci;
        logic c, v;
        ua = longint'(a); ub = longint'(b);
        sa = longint'($signed(a)); sb = longint'($signed(b));
        ci = longint'(f[1]);
        arith = 1'b1; c = 1'b0; v = f[0]; u = 0; sg = 0;
        case (op)
            4'd4, 4'd11: begin u = ua + ub;          sg = sa + sb;          c = u > 64'hFFFF_FFFF; end
            4'd5:        begin u = ua + ub + ci;     sg = sa + sb + ci;     c = u > 64'hFFFF_FFFF; end
            4'd2, 4'd10: begin u = ua - ub;          sg = sa - sb;          c = u >= 0; end
            4'd6:        begin u = ua - ub + ci - 1; sg = sa - sb + ci - 1; c = u >= 0; end
            4'd3:        begin u = ub - ua;          sg = sb - sa;          c = u >= 0; end
            4'd7:        begin u = ub - ua + ci - 1; sg = sb - sa + ci - 1; c = u >= 0; end
            default:     arith = 1'b0;
        endcase
        if (arith) begin
            r = u[31:0];
            v = (sg > 64'sd2147483647) || (sg < -64'sd2147483648);
        end else begin
            case (op)
                4'd0, 4'd8: r = a & b;
                4'd1, 4'd9: r = a ^ b;
                4'd12:      r = a | b;
                4'd13:      r = b;
                4'd14:      r = a & ~b;
                default:    r = ~b;
            endcase
            c = sc;
        end
        we = !(op >= 4'd8 && op <= 4'd11);
        if (s || !we) nf = {r[31], r == 32'd0, c, v};
        else          nf = f;
    endfunction

    task automatic run_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic sc, input logic s);
        logic [31:0] er; logic ew, ar; logic [3:0] enf;
        model(op, a, b, mf, sc, s, er, ew, enf, ar);
        @(negedge clk);
        op_code = op; opnd_a = a; opnd_b = b; shift_carry = sc; set_flags = s;
        #1;
        chk(ar ? "R2" : "R1", $sformatf("result op%0d", op), result, er);
        chk("R3", "dest_we", {31'd0, dest_we}, {31'd0, ew});
        chk("R11", "flags before edge", {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, mf});
        @(posedge clk); #1;
        if (!ew && !s)       chk("R9", "flags compare", {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, enf});
        else if (!s)         chk("R8", "flags hold", {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, enf});
        else begin
            chk("R4", "N,Z", {30'd0, flag_n, flag_z}, {30'd0, enf[3:2]});
            chk(ar ? "R6" : "R5", "C", {31'd0, flag_c}, {31'd0, enf[1]});
            chk(ar ? "R7" : "R5", "V", {31'd0, flag_v}, {31'd0, enf[0]});
        end
        mf = {flag_n, flag_z, flag_c, flag_v} === enf ? enf : enf;
    endtask

    initial begin : watchdog
        #1500000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        logic [31:0] corner [4];
        logic [31:0] ra, rb;
        int unused;
        corner[0] = 32'h0000_0000; corner[1] = 32'h7FFF_FFFF;
        corner[2] = 32'h8000_0000; corner[3] = 32'hFFFF_FFFF;
        unused = $urandom(32'd1234);
        repeat (3) @(posedge clk);
        #1;
        chk("R10", "reset flags", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // Directed corners: preset carry through a flag-setting MOV, then apply the code.
        for (int op = 0; op < 16; op++)
            for (int ci = 0; ci < 2; ci++)
                for (int i = 0; i < 4; i++)
                    for (int j = 0; j < 4; j++) begin
                        run_op(4'd13, 32'd1, 32'd1, ci[0], 1'b1);
                        run_op(op[3:0], corner[i], corner[j], ~ci[0], 1'b1);
                    end

        // Random mix, operands sometimes taken from the corner set.
        for (int k = 0; k < 3000; k++) begin
            ra = ($urandom % 4 == 0) ? corner[$urandom % 4] : $urandom;
            rb = ($urandom % 4 == 0) ? corner[$urandom % 4] : $urandom;
            run_op(4'($urandom % 16), ra, rb, 1'($urandom % 2), 1'($urandom % 2));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule